// File: doc/BRIEF.md
# Segmented MMIO Window Decoder

This block decides whether a host address belongs to the memory-mapped region that a downstream bus owns. The top sixteenth of the 32-bit address space is split into 32 equal windows of 8 MB each. A 32-bit enable register holds one bit per window. Bit i turns on the window that starts at 0xF0000000 + i * 0x00800000. The decoder is a bit-indexed window selector and does no base/limit comparison. When several neighbouring bits are set, their windows form one unbroken decoded range.

Each request carries a valid strobe, an address and a space flag. The flag tells a memory access from an I/O-port access, and only memory accesses take part in decoding. One clock after a valid memory request, the block registers a claim flag and the 5-bit index of the window that matched. Software loads the enable register through a small write port at offset 0x060 and can read it back at the same offset. After reset every enable bit is clear, so nothing is claimed until software sets at least one bit.

Top module: `seg_window_decode`

## Requirements
- R1: After reset the enable register reads 0x00000000, `hitClaim` is 0 and `hitIndex` is 0.
- R2: A write with `cfgWrEn`=1 and `cfgAddr`=0x060 loads all 32 bits of `cfgWrData` into the enable register. While `cfgAddr`=0x060, `cfgRdData` shows that value unchanged in the same cycle. At any other `cfgAddr`, `cfgRdData` is 0.
- R3: A write to any `cfgAddr` other than 0x060 changes neither the read-back value nor the decoding.
- R4: A request with `reqValid`=1, `reqIsMem`=1, `reqAddr[31:28]`=0xF and enable bit `reqAddr[27:23]` set raises `hitClaim` at the next rising edge. At that same edge `hitIndex` takes the value `reqAddr[27:23]`.
- R5: An address whose bits [31:28] differ from 0xF is never claimed, whatever the enables.
- R6: An address that falls in a window whose enable bit is 0 is not claimed. With the enable register at zero, no address is claimed.
- R7: A request with `reqIsMem`=0 (I/O-port space) is never claimed, whatever the address and the enables.
- R8: When windows i..j are all enabled, every address from 0xF0000000+i*8MB to 0xF0000000+(j+1)*8MB-1 is claimed, both ends included. The address just below that range and the address just above it are not claimed when their own windows are disabled.
- R9: `hitClaim` is 1 only in the cycle after a sampled valid request. Whenever `hitClaim` is 0, `hitIndex` is 0.
- R10: A request presented in the same cycle as an enable write is decoded with the enable value from before the write. The new value applies from the next request on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe for this cycle |
| reqAddr | input | 32 | Host address to decode |
| reqIsMem | input | 1 | 1 = memory-mapped access, 0 = I/O-port access |
| cfgWrEn | input | 1 | Register write strobe |
| cfgAddr | input | 12 | Register offset for write and read-back |
| cfgWrData | input | 32 | Register write data |
| cfgRdData | output | 32 | Enable register read-back (0 at other offsets) |
| hitClaim | output | 1 | Registered claim, one cycle after the request |
| hitIndex | output | 5 | Index of the claimed window, 0 when there is no claim |

## Verification
The assertions check on every cycle that any claim has a cause. A claim must follow a valid memory request in the top region. The address of that request must lie inside the claimed window, and the enable register must have been non-zero. The per-window match vector must be at most one-hot, the index must be zero when there is no claim, and the enable register must not change without a write strobe. Some properties can only be shown by the bench scenarios. These are the read-back path, writes to other offsets being ignored, and the window edges of a contiguous group of enables. The bench also shows which enable value a request sees when it arrives in the same cycle as a write, and that a claim does occur whenever one is due.

// File: rtl/seg_win_pkg.sv
package seg_win_pkg;

  // Strobes passed from the control decode to the datapath.
  typedef struct packed {
    logic loadEnable;  // load the enable register this cycle
    logic sampleReq;   // a request is presented this cycle
    logic readSel;     // read-back offset selected
  } winStrobes_t;

endpackage

// File: rtl/seg_win_ctrl.sv
module seg_win_ctrl
  import seg_win_pkg::*;
#(
  parameter int REG_AW = 12,
  parameter logic [REG_AW-1:0] EN_OFFSET = 12'h060
) (
  input  logic              reqValid,
  input  logic              cfgWrEn,
  input  logic [REG_AW-1:0] cfgAddr,
  output winStrobes_t       strobes
);

  logic offsetHit;

  assign offsetHit          = (cfgAddr == EN_OFFSET);
  assign strobes.loadEnable = cfgWrEn && offsetHit;
  assign strobes.sampleReq  = reqValid;
  assign strobes.readSel    = offsetHit;

endmodule

// File: rtl/seg_win_datapath.sv
module seg_win_datapath
  import seg_win_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int REGION_W  = 4,
  parameter logic [REGION_W-1:0] REGION_TAG = 4'hF,
  parameter int WIN_SHIFT = 23,
  parameter int WIN_CNT   = 32,
  localparam int IDX_W    = $clog2(WIN_CNT)
) (
  input  logic               clk,
  input  logic               rstN,
  input  winStrobes_t        strobes,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic               reqIsMem,
  input  logic [WIN_CNT-1:0] wrData,
  output logic [WIN_CNT-1:0] rdData,
  output logic               claimQ,
  output logic [IDX_W-1:0]   idxQ
);

  logic [WIN_CNT-1:0] enableReg;
  logic [WIN_CNT-1:0] winHit;
  logic [IDX_W-1:0]   reqIdx;
  logic [IDX_W-1:0]   hitIdx;
  logic               regionOk;
  logic               anyHit;

  // Enable register: one bit per window, cleared by reset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableReg <= '0;
    end else if (strobes.loadEnable) begin
      enableReg <= wrData;
    end
  end

  assign rdData   = strobes.readSel ? enableReg : '0;
  assign reqIdx   = reqAddr[WIN_SHIFT +: IDX_W];
  assign regionOk = reqIsMem && (reqAddr[ADDR_W-1 -: REGION_W] == REGION_TAG);

  // One comparator per window; at most one can match.
  for (genvar w = 0; w < WIN_CNT; w++) begin : g_win
    assign winHit[w] = regionOk && enableReg[w] && (reqIdx == IDX_W'(w));
  end

  assign anyHit = |winHit;

  always_comb begin
    hitIdx = '0;
    for (int w = 0; w < WIN_CNT; w++) begin
      if (winHit[w]) hitIdx = IDX_W'(w);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      claimQ <= 1'b0;
      idxQ   <= '0;
    end else begin
      claimQ <= strobes.sampleReq && anyHit;
      idxQ   <= (strobes.sampleReq && anyHit) ? hitIdx : '0;
    end
  end

  // Base address of the window named by the registered index.
  logic [ADDR_W-1:0] winBase;
  assign winBase = (ADDR_W'(REGION_TAG) << (ADDR_W - REGION_W)) | (ADDR_W'(idxQ) << WIN_SHIFT);

  a_r4_single_window: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(winHit));

  a_r9_claim_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    claimQ |-> $past(strobes.sampleReq));

  a_r7_io_never_claims: assert property (@(posedge clk) disable iff (!rstN)
    claimQ |-> $past(reqIsMem));

  a_r5_top_region_only: assert property (@(posedge clk) disable iff (!rstN)
    claimQ |-> ($past(reqAddr[ADDR_W-1 -: REGION_W]) == REGION_TAG));

  a_r8_addr_in_window: assert property (@(posedge clk) disable iff (!rstN)
    claimQ |-> (($past(reqAddr) - winBase) < (ADDR_W'(1) << WIN_SHIFT)));

  a_r6_zero_enables: assert property (@(posedge clk) disable iff (!rstN)
    claimQ |-> ($past(enableReg) != '0));

  a_r9_idle_index: assert property (@(posedge clk) disable iff (!rstN)
    !claimQ |-> (idxQ == '0));

  a_r3_hold_enables: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadEnable |=> (enableReg == $past(enableReg)));

endmodule

// File: rtl/seg_window_decode.sv
module seg_window_decode
  import seg_win_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int REGION_W  = 4,
  parameter logic [REGION_W-1:0] REGION_TAG = 4'hF,
  parameter int WIN_SHIFT = 23,
  parameter int WIN_CNT   = 32,
  parameter int REG_AW    = 12,
  parameter logic [REG_AW-1:0] EN_OFFSET = 12'h060,
  localparam int IDX_W    = $clog2(WIN_CNT)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic               reqIsMem,
  input  logic               cfgWrEn,
  input  logic [REG_AW-1:0]  cfgAddr,
  input  logic [WIN_CNT-1:0] cfgWrData,
  output logic [WIN_CNT-1:0] cfgRdData,
  output logic               hitClaim,
  output logic [IDX_W-1:0]   hitIndex
);

  winStrobes_t strobes;

  seg_win_ctrl #(
    .REG_AW   (REG_AW),
    .EN_OFFSET(EN_OFFSET)
  ) u_ctrl (
    .reqValid(reqValid),
    .cfgWrEn (cfgWrEn),
    .cfgAddr (cfgAddr),
    .strobes (strobes)
  );

  seg_win_datapath #(
    .ADDR_W    (ADDR_W),
    .REGION_W  (REGION_W),
    .REGION_TAG(REGION_TAG),
    .WIN_SHIFT (WIN_SHIFT),
    .WIN_CNT   (WIN_CNT)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .reqAddr (reqAddr),
    .reqIsMem(reqIsMem),
    .wrData  (cfgWrData),
    .rdData  (cfgRdData),
    .claimQ  (hitClaim),
    .idxQ    (hitIndex)
  );

endmodule

// File: tb/sim_seg_window_decode.sv
module sim_seg_window_decode;

  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] EN_OFS = 12'h060;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqIsMem = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [11:0] cfgAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic        hitClaim;
  logic [4:0]  hitIndex;

  int checks = 0;
  int errors = 0;
  logic [31:0] modelEn = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_window_decode u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqIsMem(reqIsMem), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .hitClaim(hitClaim), .hitIndex(hitIndex)
  );

  function automatic logic expClaim(logic [31:0] a, logic mem, logic [31:0] en);
    return mem && (a[31:28] == 4'hF) && en[a[27:23]];
  endfunction

  function automatic logic [4:0] expIdx(logic [31:0] a, logic mem, logic [31:0] en);
    return expClaim(a, mem, en) ? a[27:23] : 5'd0;
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Register write; drives at the falling edge, takes effect at the next rising edge.
  task automatic cfgWrite(input logic [11:0] ofs, input logic [31:0] val);
    cfgWrEn = 1'b1; cfgAddr = ofs; cfgWrData = val;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgAddr = '0; cfgWrData = '0;
    if (ofs == EN_OFS) modelEn = val;
  endtask

  task automatic checkReadback(input string req);
    cfgAddr = EN_OFS;
    #1;
    check(cfgRdData == modelEn, req, cfgRdData, modelEn);
    cfgAddr = '0;
  endtask

  // One request; the outputs are checked at the next falling edge.
  task automatic doReq(input logic [31:0] a, input logic mem, input string req);
    logic       eClaim;
    logic [4:0] eIdx;
    eClaim = expClaim(a, mem, modelEn);
    eIdx   = expIdx(a, mem, modelEn);
    reqValid = 1'b1; reqAddr = a; reqIsMem = mem;
    @(negedge clk);
    reqValid = 1'b0;
    check(hitClaim == eClaim, req, 32'(hitClaim), 32'(eClaim));
    check(hitIndex == eIdx, req, 32'(hitIndex), 32'(eIdx));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);

    // R1: reset state, checked while reset is still active
    cfgAddr = EN_OFS; #1;
    check(cfgRdData == 32'h0, "R1 enable reset", cfgRdData, 32'h0);
    check(hitClaim == 1'b0, "R1 claim reset", 32'(hitClaim), 32'h0);
    check(hitIndex == 5'd0, "R1 index reset", 32'(hitIndex), 32'h0);
    cfgAddr = '0;
    rstN = 1'b1;
    @(negedge clk);

    // R6: nothing is decoded while every enable bit is clear
    doReq(32'hF000_0000, 1'b1, "R6 zero enables low");
    doReq(32'hFFFF_FFFF, 1'b1, "R6 zero enables high");

    // R2: load the register and read it back
    cfgWrite(EN_OFS, 32'hA5C3_0F01);
    checkReadback("R2 readback");
    cfgAddr = 12'h064; #1;
    check(cfgRdData == 32'h0, "R2 other offset reads zero", cfgRdData, 32'h0);
    cfgAddr = '0;

    // R3: writes to other offsets are ignored
    cfgWrite(12'h05C, 32'hFFFF_FFFF);
    cfgWrite(12'h061, 32'h0000_0000);
    checkReadback("R3 readback after foreign writes");
    doReq(32'hF080_0000, 1'b1, "R3 window 1 stays disabled");

    // R4 / R6: hits and misses in single windows
    doReq(32'hF000_1234, 1'b1, "R4 window 0");
    doReq(32'hFF80_0000, 1'b1, "R4 window 31");
    doReq(32'hF100_0004, 1'b1, "R6 window 2 disabled");

    // R5: outside the top region
    cfgWrite(EN_OFS, 32'hFFFF_FFFF);
    doReq(32'hE000_0000, 1'b1, "R5 below region");
    doReq(32'h7080_0000, 1'b1, "R5 low region");
    doReq(32'hEFFF_FFFF, 1'b1, "R5 just below region");

    // R7: I/O-port space never claimed
    doReq(32'hF000_0000, 1'b0, "R7 io low");
    doReq(32'hF480_0010, 1'b0, "R7 io mid");

    // R8: windows 5..7 contiguous
    cfgWrite(EN_OFS, 32'h0000_00E0);
    doReq(32'hF280_0000, 1'b1, "R8 range start");
    doReq(32'hF2FF_FFFF, 1'b1, "R8 inner edge 5");
    doReq(32'hF300_0000, 1'b1, "R8 inner edge 6");
    doReq(32'hF3FF_FFFF, 1'b1, "R8 range end");
    doReq(32'hF27F_FFFF, 1'b1, "R8 below range");
    doReq(32'hF400_0000, 1'b1, "R8 above range");

    // R9: no valid means no claim, even with a matching address
    reqAddr = 32'hF280_0000; reqIsMem = 1'b1; reqValid = 1'b0;
    @(negedge clk);
    check(hitClaim == 1'b0, "R9 no valid no claim", 32'(hitClaim), 32'h0);
    check(hitIndex == 5'd0, "R9 idle index", 32'(hitIndex), 32'h0);

    // R10: request in the same cycle as a write sees the old value
    cfgWrEn = 1'b1; cfgAddr = EN_OFS; cfgWrData = 32'h0000_0100;
    reqValid = 1'b1; reqAddr = 32'hF400_0000; reqIsMem = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgAddr = '0; reqValid = 1'b0;
    check(hitClaim == 1'b0, "R10 old enables used", 32'(hitClaim), 32'h0);
    modelEn = 32'h0000_0100;
    doReq(32'hF400_0000, 1'b1, "R10 new enables next request");

    // Random mix of writes and requests (R4, R5, R6, R7)
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      logic        m;
      if (($urandom % 16) == 0) cfgWrite(EN_OFS, $urandom);
      a = $urandom;
      if (($urandom % 4) != 0) a[31:28] = 4'hF;
      m = (($urandom % 5) != 0);
      doReq(a, m, "R4 random");
    end
    checkReadback("R2 final readback");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule